// File: doc/BRIEF.md
# Display RAM Host Holder Bridge

This block sits between an asynchronous host parallel bus and the internal display RAM of a dot-matrix panel controller. A single byte register, the holder, buffers every display-data transfer in both directions. The host therefore never waits: there is no ready line, and each strobe only has to meet the bus cycle time. A write places the byte in the holder, and the block then commits it to RAM at the current column before the next strobe can arrive. A read puts the byte that is already in the holder onto the bus. After the strobe ends, the block refills the holder from the current column.

Reads are pipelined one deep. The byte a read returns was therefore fetched by the previous read. After a column load or a write, the first read gives back old holder contents and must be thrown away; correct data starts with the second read. The column counter advances after every display-data access and wraps at the last column. A column load from the internal side sets it directly.

The strobes and the two selects are asynchronous to the system clock and pass through synchronisers. An access takes effect on the deasserting (rising) edge of its strobe. The host keeps data, mode and selects steady from the falling edge of the strobe until three clocks after its rising edge.

Top module: `hb_dram_bridge`

## Requirements
- R1: The host bus has an effect only while `host_cs_n` is 0 and `host_cs` is 1. A strobe given while either select is inactive issues no RAM access, leaves the holder and the column unchanged, and keeps `host_doe` at 0.
- R2: `host_doe` is 1 only while the bus is selected, `host_dsel` is 1 and `host_rd_n` is low, all seen after synchronisation. `host_dout` then shows the holder byte.
- R3: When `host_wr_n` rises with `host_dsel` = 1, `host_din` is copied into the holder. Exactly one `ram_we` pulse then writes that byte to the current column.
- R4: When `host_rd_n` rises with `host_dsel` = 1, exactly one `ram_re` pulse reads the current column. The returned byte is loaded into the holder and is presented by the next read.
- R5: The first read after a column load returns the holder byte fetched before the load. The second read returns the RAM byte at the loaded column.
- R6: A read that follows a write returns the byte that was just written, not RAM data.
- R7: The column advances by one after each display-data write and after each display-data read. It goes from COLS-1 back to 0.
- R8: A pulse on `col_load` sets the column to `col_value` if that value is below COLS. A value of COLS or more is ignored and the column stays unchanged.
- R9: Strobes with `host_dsel` = 0 (command mode) cause no RAM access, no holder change and no column change, and a command-mode read keeps `host_doe` at 0.
- R10: After reset the holder is 0x00, the column is 0, and `ram_we`, `ram_re` and `host_doe` are 0.
- R11: With no wait signal, the RAM write pulse comes within 4 clocks of the rise of `host_wr_n`. A read's holder refill finishes within 7 clocks of the rise of `host_rd_n`. No new access is detected while a commit or refill is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Active-low host select |
| host_cs | input | 1 | Active-high host select |
| host_dsel | input | 1 | 1 = display data access, 0 = command access |
| host_rd_n | input | 1 | Active-low read strobe (acts on its rise) |
| host_wr_n | input | 1 | Active-low write strobe (acts on its rise) |
| host_din | input | DW | Byte driven by the host |
| host_dout | output | DW | Holder byte toward the host |
| host_doe | output | 1 | Data bus drive enable; 0 means high impedance |
| col_load | input | 1 | One-cycle column load request |
| col_value | input | AW | Column to load |
| ram_addr | output | AW | RAM column address |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable (data valid one cycle later) |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data |

## Verification
The bench fills every column with an arithmetic byte pattern and then reads the whole array back in one pass that runs past the last column. That pass separates real data from stale holder contents and shows whether the column wraps. A column load in mid-array followed by reads separates the dummy byte from the loaded location, and an out-of-range load shows whether the column moved. Deselected and command-mode strobes, each followed by reads that continue the known pattern, show that the holder and the column were left untouched. Pulse counts on the RAM port confirm that exactly one access happens per strobe and that it comes within the stated number of clocks.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int BYTE_W = 8;

  // positions in the synchronised host control vector
  localparam int SIG_WR   = 0;
  localparam int SIG_RD   = 1;
  localparam int SIG_NSEL = 2;
  localparam int SIG_MODE = 3;
  localparam int SIG_N    = 4;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;
endpackage

// File: rtl/hb_strobe_sync.sv
module hb_strobe_sync #(
  parameter int             N       = 4,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  localparam int CHAIN = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [CHAIN-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {CHAIN{RST_VAL[g]}};
      else     chain <= {chain[CHAIN-2:0], async_in[g]};
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
  end
endmodule

// File: rtl/hb_col_counter.sv
module hb_col_counter #(
  parameter int COLS = 132,
  parameter int AW   = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] col
);
  localparam logic [AW-1:0] LAST = AW'(COLS - 1);

  logic load_ok;
  assign load_ok = load && (int'(load_val) < COLS);

  always_ff @(posedge clk) begin
    if (rst)          col <= '0;
    else if (load_ok) col <= load_val;
    else if (step)    col <= (col == LAST) ? '0 : col + 1'b1;
  end

  // R7
  col_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(col) < COLS);

  // R8
  col_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (load && int'(load_val) >= COLS && !step) |=> $stable(col));
endmodule

// File: rtl/hb_holder_pipe.sv
module hb_holder_pipe
  import hb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  acc_e          acc,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] col,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_wdata,
  output logic [DW-1:0] holder,
  output logic          busy
);
  logic fill_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_wdata <= '0;
      holder    <= '0;
      fill_pend <= 1'b0;
    end else begin
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      fill_pend <= ram_re;
      unique case (acc)
        ACC_WRITE: begin
          holder    <= wdata;
          ram_we    <= 1'b1;
          ram_addr  <= col;
          ram_wdata <= wdata;
        end
        ACC_READ: begin
          ram_re   <= 1'b1;
          ram_addr <= col;
        end
        default: ;
      endcase
      if (fill_pend) holder <= ram_rdata;
    end
  end

  assign busy = ram_we | ram_re | fill_pend;

  // R3
  wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WRITE) |=> (ram_we && ram_wdata == $past(wdata) && ram_addr == $past(col)));

  // R4
  rd_refill_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_READ) |=> ##2 (holder == $past(ram_rdata)));

  // R4
  ram_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, ram_re}));
endmodule

// File: rtl/hb_dram_bridge.sv
module hb_dram_bridge
  import hb_pkg::*;
#(
  parameter int COLS        = 132,
  parameter int DW          = BYTE_W,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs_n,
  input  logic          host_cs,
  input  logic          host_dsel,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  input  logic          col_load,
  input  logic [AW-1:0] col_value,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  localparam logic [SIG_N-1:0] SYNC_RST = 4'b0111;
  localparam logic [AW-1:0]    LAST_COL = AW'(COLS - 1);

  logic [SIG_N-1:0] raw_ctl, ctl_lvl, ctl_rise;
  logic             sel_ok, gate, wr_evt, rd_evt, busy;
  logic [AW-1:0]    col;
  logic [DW-1:0]    holder;
  acc_e             acc;

  assign raw_ctl[SIG_WR]   = host_wr_n;
  assign raw_ctl[SIG_RD]   = host_rd_n;
  assign raw_ctl[SIG_NSEL] = ~(~host_cs_n & host_cs);
  assign raw_ctl[SIG_MODE] = host_dsel;

  hb_strobe_sync #(.N(SIG_N), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rst(rst), .async_in(raw_ctl), .lvl(ctl_lvl), .rise(ctl_rise));

  assign sel_ok = ~ctl_lvl[SIG_NSEL];
  assign gate   = sel_ok & ctl_lvl[SIG_MODE];
  assign wr_evt = ctl_rise[SIG_WR] & gate;
  assign rd_evt = ctl_rise[SIG_RD] & gate & ~wr_evt;

  always_comb begin
    if (wr_evt)      acc = ACC_WRITE;
    else if (rd_evt) acc = ACC_READ;
    else             acc = ACC_IDLE;
  end

  hb_col_counter #(.COLS(COLS), .AW(AW)) i_col (
    .clk(clk), .rst(rst), .load(col_load), .load_val(col_value),
    .step(wr_evt | rd_evt), .col(col));

  hb_holder_pipe #(.AW(AW), .DW(DW)) i_pipe (
    .clk(clk), .rst(rst), .acc(acc), .wdata(host_din), .col(col),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_re(ram_re), .ram_wdata(ram_wdata), .holder(holder), .busy(busy));

  always_ff @(posedge clk) begin
    if (rst) host_doe <= 1'b0;
    else     host_doe <= gate & ~ctl_lvl[SIG_RD];
  end

  assign host_dout = holder;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_ok |=> !host_doe);

  // R7
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((ram_we || ram_re) && !$past(col_load)) |->
      (col == ((ram_addr == LAST_COL) ? '0 : ram_addr + 1'b1)));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (acc == ACC_IDLE));
endmodule

// File: tb/test_hb_dram_bridge.sv
module test_hb_dram_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 12;
  localparam int AW = $clog2(COLS);
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_cs_n = 1'b1, host_cs = 1'b0, host_dsel = 1'b0;
  logic host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [DW-1:0] host_din = '0;
  logic [DW-1:0] host_dout;
  logic host_doe;
  logic col_load = 1'b0;
  logic [AW-1:0] col_value = '0;
  logic [AW-1:0] ram_addr;
  logic ram_we, ram_re;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;

  logic [DW-1:0] mem [COLS];
  int we_cnt = 0, re_cnt = 0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_dram_bridge #(.COLS(COLS)) i_hb_dram_bridge (
    .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_cs(host_cs),
    .host_dsel(host_dsel), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
    .col_load(col_load), .col_value(col_value), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata));

  // synchronous RAM, one-cycle read latency
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
    if (!rst && ram_we) we_cnt <= we_cnt + 1;
    if (!rst && ram_re) re_cnt <= re_cnt + 1;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic cs_n, input logic cs, input logic dsel);
    @(negedge clk);
    host_cs_n = cs_n; host_cs = cs; host_dsel = dsel;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d, input logic cs_n, input logic cs,
                            input logic dsel, output int lat, output int pulses);
    int we0;
    lat = 0;
    host_din = d;
    setup(cs_n, cs, dsel);
    host_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    we0 = we_cnt;
    host_wr_n = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (lat == 0 && ram_we) lat = k;
    end
    pulses = we_cnt - we0;
  endtask

  task automatic host_read(input logic cs_n, input logic cs, input logic dsel,
                           output logic [7:0] d, output logic oe, output int pulses);
    int re0;
    setup(cs_n, cs, dsel);
    host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    d = host_dout; oe = host_doe;
    re0 = re_cnt;
    host_rd_n = 1'b1;
    repeat (10) @(negedge clk);
    pulses = re_cnt - re0;
  endtask

  task automatic load_col(input int v);
    @(negedge clk);
    col_load = 1'b1; col_value = AW'(v);
    @(negedge clk);
    col_load = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_expect(input string req, input int exp);
    logic [7:0] d; logic oe; int p;
    host_read(1'b0, 1'b1, 1'b1, d, oe, p);
    chk(req, d, exp);
    chk({req, " one ram_re"}, p, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d; logic oe; int lat, p, we0, re0;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 doe", host_doe, 0);
    chk("R10 ram_we", ram_we, 0);
    chk("R10 ram_re", ram_re, 0);
    chk("R10 holder", host_dout, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R3/R7/R8/R11: fill every column
    load_col(0);
    for (int i = 0; i < COLS; i++) begin
      host_write(pat(i), 1'b0, 1'b1, 1'b1, lat, p);
      chk("R3 ram content", mem[i], pat(i));
      chk("R3 one ram_we", p, 1);
      if (i == 0) begin
        chk("R11 write latency ok", int'(lat >= 1 && lat <= 4), 1);
      end
    end

    // R6: read after write returns last written byte; R2 drive
    host_read(1'b0, 1'b1, 1'b1, d, oe, p);
    chk("R6 stale after write", d, pat(COLS - 1));
    chk("R2 doe during read", oe, 1);

    // R4/R7: read whole array across the wrap
    for (int j = 0; j < COLS; j++) rd_expect("R4 readback", pat(j));

    // R5: dummy read after column load
    load_col(5);
    rd_expect("R5 stale after load", pat(0));
    rd_expect("R5 valid second read", pat(5));
    rd_expect("R7 next column", pat(6));

    // R8: out-of-range load ignored
    load_col(13);
    rd_expect("R8 holder", pat(7));
    rd_expect("R8 column unchanged", pat(8));

    // R1: deselected strobes
    we0 = we_cnt; re0 = re_cnt;
    host_write(8'hAA, 1'b1, 1'b1, 1'b1, lat, p);
    host_write(8'hAB, 1'b0, 1'b0, 1'b1, lat, p);
    host_read(1'b1, 1'b1, 1'b1, d, oe, p);
    chk("R1 doe low deselected", oe, 0);
    host_read(1'b0, 1'b0, 1'b1, d, oe, p);
    chk("R1 doe low cs inactive", oe, 0);
    chk("R1 no ram access", (we_cnt - we0) + (re_cnt - re0), 0);
    rd_expect("R1 holder kept", pat(9));
    rd_expect("R1 column kept", pat(10));

    // R9: command-mode strobes
    we0 = we_cnt; re0 = re_cnt;
    host_write(8'h55, 1'b0, 1'b1, 1'b0, lat, p);
    host_read(1'b0, 1'b1, 1'b0, d, oe, p);
    chk("R9 doe low command read", oe, 0);
    chk("R9 no ram access", (we_cnt - we0) + (re_cnt - re0), 0);
    rd_expect("R9 holder and column kept", pat(11));
    for (int i = 0; i < COLS; i++) chk("R1 R9 ram untouched", mem[i], pat(i));

    // R11: read refill completes within 7 clocks of strobe rise
    load_col(2);
    setup(1'b0, 1'b1, 1'b1);
    host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    host_rd_n = 1'b1;
    repeat (7) @(negedge clk);
    chk("R11 refill time", host_dout, pat(2));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule